// File: doc/BRIEF.md
# Memory Controller Register Block

This block holds the control and status registers of one memory controller on a backplane. A simple slave bus addresses it in bytes. Bits [1:0] of the address must be zero, and the remaining bits form a longword index. Four 32-bit registers respond at longword indices 0 to 3:

- Configuration (A) holds the array size, the chip type and the interleave setting.
- Start-address (B) holds the start address, the diagnostic check bits and the refresh control.
- Two error registers (C and D) hold error flags and a control bit.

Longword indices from 0x400 upward read a small computed configuration ROM. Some fields accept write data only when an enable bit in the same write word is 1. Error flags are set by hardware event inputs and cleared by writing one.

A static strap input selects between two variants. In the basic variant register D does not exist. In the extended variant more error bits exist, register D is present, and register A reports an error summary. The reset contents of A and B depend on the strap and on three parameters: the controller index, the per-controller size in kilobytes and the ROM seed. Each request is answered exactly one cycle later with an acknowledge, a response code and read data. A malformed access also produces a one-cycle error-confirmation pulse.

Top module: `memctl_csr`

## Requirements
- R1: During and after synchronous reset, C and D read as 0. B holds 0x3000 ORed with (CTRL_IDX × SIZE_KB) shifted left by 9. A holds the size field in bits [14:9] and the type code in bits [7:0]. In the basic variant the size field is SIZE_KB/64 − 1 and the type is 0x08 when SIZE_KB ≤ 1024, else 0x10. In the extended variant, with MB = SIZE_KB/1024, the size field is MB − 1 and the type is 0x68 when MB ≤ 16, else 0x70.
- R2: A request cycle produces ack = 1 in the next cycle only. Without a request, ack is 0. A write, or any non-OK response, returns rdata = 0.
- R3: An access is refused when is_long = 0 or addr[1:0] ≠ 0. A refused access returns resp = 2 (bad access) with errconf = 1 for that single cycle and changes no register.
- R4: A write to A always loads bit 8. It loads bits [2:0] only when wdata[8] = 1 and leaves every other bit unchanged. A read of A returns bits [14:0] plus bit 20 (see R11).
- R5: A write to B always loads bits [10:0] except bit 11, and also loads bit 14. It loads bits [27:15] only when wdata[14] = 1. A read of B returns the stored value with bit 11 forced to 0 and bits [13:12] forced to 1.
- R6: In C, bit 30 is a plain read/write bit. Writing 1 clears bits 29 and 28. In the extended variant, writing 1 also clears bits 19, 18, 9, 8 and 7. A read of C is masked with 0x7FFFFFFF in the basic variant and 0x700C0380 in the extended variant.
- R7: set_c[i] (and set_d[i] in the extended variant) sets bit i of C (or D) at the next edge, for each bit that R6 lets software clear in the current variant. A set in the same cycle as a write-one clear of that bit wins.
- R8: In the extended variant, D follows the R6 rules with the extended read mask. In the basic variant any access to D returns resp = 1 (non-existent) and has no effect.
- R9: resp = 1 is returned for all of the following: longword indices 4 to 0x3FF, ROM indices at or beyond 0x400 + ROM_WORDS, and every write to the ROM range.
- R10: A read of longword index 0x400 + k, for k < ROM_WORDS, returns (ROM_SEED + k × 0x01010101) mod 2^32 with resp = 0.
- R11: A read of A returns bit 20 = 1 in the extended variant when any of bits 29, 28, 19, 18, 9, 8 or 7 is set in C or D. In the basic variant bit 20 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_variant | input | 1 | Variant strap: 0 basic, 1 extended; sampled for reset values |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 write, 0 read |
| is_long | input | 1 | 1 when the access is longword-sized |
| addr | input | ADDR_W | Byte address within the block |
| wdata | input | 32 | Write data |
| set_c | input | 32 | Per-bit hardware error events for C |
| set_d | input | 32 | Per-bit hardware error events for D |
| ack | output | 1 | Acknowledge, one cycle after req |
| resp | output | 2 | 0 ok, 1 non-existent, 2 bad access |
| rdata | output | 32 | Read data, valid with ack |
| errconf | output | 1 | One-cycle error-confirmation pulse on a bad access |

## Verification
Every bus result is due one edge after its request cycle: ack, resp, rdata and errconf are all registered once. A register write or a hardware error event becomes visible to the first read issued after that edge. The bench's reference model works out, at each rising edge, the outputs that edge must produce and the register contents it leaves behind. It compares the design's outputs against that prediction at the following falling edge, every cycle including reset and idle cycles. Simultaneous event-and-clear cycles and summary reads are ordered so that the value each read must return is fixed by the preceding edge alone.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    typedef enum logic [1:0] {
        RSP_OK  = 2'd0,
        RSP_NXM = 2'd1,
        RSP_BAD = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        TG_A,
        TG_B,
        TG_C,
        TG_D,
        TG_ROM,
        TG_NONE
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        rsp_e rsp;
    } dec_t;

    localparam int unsigned ROM_BASE_IDX = 32'h400;

    localparam logic [31:0] A_WR_ALWAYS   = 32'h0000_0100;
    localparam logic [31:0] A_ILV         = 32'h0000_0007;
    localparam logic [31:0] A_RMASK       = 32'h0000_7FFF;
    localparam int unsigned A_SUMM_BIT    = 20;

    localparam logic [31:0] B_WR_ALWAYS   = 32'h0000_47FF & ~32'h0000_0800 & ~32'h0000_0000;
    localparam logic [31:0] B_START       = 32'h0FFF_8000;
    localparam logic [31:0] B_RMASK       = 32'hFFFF_F7FF;
    localparam logic [31:0] B_FORCE       = 32'h0000_3000;

    localparam logic [31:0] E_RW          = 32'h4000_0000;
    localparam logic [31:0] E_W1C_BASIC   = 32'h3000_0000;
    localparam logic [31:0] E_W1C_EXT     = 32'h300C_0380;
    localparam logic [31:0] E_RMASK_BASIC = 32'h7FFF_FFFF;
    localparam logic [31:0] E_RMASK_EXT   = 32'h700C_0380;

    function automatic logic [31:0] err_clear_mask(input logic ext);
        return ext ? E_W1C_EXT : E_W1C_BASIC;
    endfunction

    function automatic logic [31:0] reset_a(input logic ext, input int unsigned kb);
        int unsigned mb;
        int unsigned fld;
        logic [31:0] ty;
        mb = kb >> 10;
        if (ext) begin
            fld = mb - 1;
            ty  = (mb <= 16) ? 32'h68 : 32'h70;
        end else begin
            fld = (kb >> 6) - 1;
            ty  = (kb <= 1024) ? 32'h08 : 32'h10;
        end
        return ((fld & 32'h3F) << 9) | ty;
    endfunction

    function automatic logic [31:0] reset_b(input int unsigned idx, input int unsigned kb);
        return B_FORCE | ((idx * kb) << 9);
    endfunction

    function automatic logic [31:0] rom_word(input logic [31:0] seed, input int unsigned k);
        return seed + k * 32'h0101_0101;
    endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int ROM_WORDS = 16,
    localparam int IDX_W    = ADDR_W - 2,
    localparam int RIDX_W   = $clog2(ROM_WORDS)
) (
    input  logic              ext,
    input  logic              wr,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [RIDX_W-1:0] rom_idx
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] roff;
    logic             in_rom;

    assign idx     = addr[ADDR_W-1:2];
    assign roff    = idx - IDX_W'(ROM_BASE_IDX);
    assign in_rom  = (idx >= IDX_W'(ROM_BASE_IDX)) && (roff < IDX_W'(ROM_WORDS));
    assign rom_idx = roff[RIDX_W-1:0];

    always_comb begin
        dec.tgt = TG_NONE;
        dec.rsp = RSP_NXM;
        if (!is_long || addr[1:0] != 2'b00) begin
            dec.rsp = RSP_BAD;
        end else if (idx == IDX_W'(0)) begin
            dec = '{tgt: TG_A, rsp: RSP_OK};
        end else if (idx == IDX_W'(1)) begin
            dec = '{tgt: TG_B, rsp: RSP_OK};
        end else if (idx == IDX_W'(2)) begin
            dec = '{tgt: TG_C, rsp: RSP_OK};
        end else if (idx == IDX_W'(3)) begin
            if (ext) dec = '{tgt: TG_D, rsp: RSP_OK};
        end else if (in_rom && !wr) begin
            dec = '{tgt: TG_ROM, rsp: RSP_OK};
        end
    end
endmodule

// File: rtl/mcsr_errreg.sv
module mcsr_errreg
    import mcsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext,
    input  logic        live,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);
    logic [31:0] w1c;
    logic [31:0] set_eff;
    logic [31:0] nxt;

    assign w1c     = err_clear_mask(ext);
    assign set_eff = hw_set & w1c & {32{live}};

    always_comb begin
        nxt = q;
        if (we) nxt = ((q & ~E_RW) | (wdata & E_RW)) & ~(wdata & w1c);
        nxt = nxt | set_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_eff) |=> ((q & $past(set_eff)) == $past(set_eff)));

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !(|set_eff)) |=> ((q & $past(wdata & w1c)) == 32'd0));
endmodule

// File: rtl/mcsr_cfgrom.sv
module mcsr_cfgrom
    import mcsr_pkg::*;
#(
    parameter int          ROM_WORDS = 16,
    parameter logic [31:0] ROM_SEED  = 32'hC0DE_0000,
    localparam int         RIDX_W    = $clog2(ROM_WORDS)
) (
    input  logic [RIDX_W-1:0] idx,
    output logic [31:0]       word
);
    logic [31:0] tbl [ROM_WORDS];

    for (genvar g = 0; g < ROM_WORDS; g++) begin : g_word
        assign tbl[g] = rom_word(ROM_SEED, g);
    end

    assign word = (32'(idx) < ROM_WORDS) ? tbl[idx] : 32'd0;
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import mcsr_pkg::*;
#(
    parameter int          ADDR_W    = 13,
    parameter int          CTRL_IDX  = 1,
    parameter int          SIZE_KB   = 1024,
    parameter int          ROM_WORDS = 16,
    parameter logic [31:0] ROM_SEED  = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_variant,
    input  logic              req,
    input  logic              wr,
    input  logic              is_long,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       set_c,
    input  logic [31:0]       set_d,
    output logic              ack,
    output logic [1:0]        resp,
    output logic [31:0]       rdata,
    output logic              errconf
);
    localparam int RIDX_W = $clog2(ROM_WORDS);

    dec_t              dec;
    logic [RIDX_W-1:0] rom_idx;
    logic [31:0]       rom_q;
    logic [31:0]       a_q, b_q, c_q, d_q;
    logic [31:0]       a_mask, b_mask, rd_word;
    logic              good, wr_a, wr_b, wr_c, wr_d, summ, bad;

    mcsr_decode #(.ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS)) u_dec (
        .ext(ext_variant), .wr(wr), .is_long(is_long), .addr(addr),
        .dec(dec), .rom_idx(rom_idx)
    );

    mcsr_cfgrom #(.ROM_WORDS(ROM_WORDS), .ROM_SEED(ROM_SEED)) u_rom (
        .idx(rom_idx), .word(rom_q)
    );

    assign good = req && (dec.rsp == RSP_OK);
    assign bad  = req && (dec.rsp == RSP_BAD);
    assign wr_a = good && wr && (dec.tgt == TG_A);
    assign wr_b = good && wr && (dec.tgt == TG_B);
    assign wr_c = good && wr && (dec.tgt == TG_C);
    assign wr_d = good && wr && (dec.tgt == TG_D);

    mcsr_errreg u_regc (
        .clk(clk), .rst(rst), .ext(ext_variant), .live(1'b1),
        .we(wr_c), .wdata(wdata), .hw_set(set_c), .q(c_q)
    );

    mcsr_errreg u_regd (
        .clk(clk), .rst(rst), .ext(ext_variant), .live(ext_variant),
        .we(wr_d), .wdata(wdata), .hw_set(set_d), .q(d_q)
    );

    assign a_mask = A_WR_ALWAYS | (wdata[8]  ? A_ILV   : 32'd0);
    assign b_mask = B_WR_ALWAYS | (wdata[14] ? B_START : 32'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= reset_a(ext_variant, SIZE_KB);
            b_q <= reset_b(CTRL_IDX, SIZE_KB);
        end else begin
            if (wr_a) a_q <= (a_q & ~a_mask) | (wdata & a_mask);
            if (wr_b) b_q <= (b_q & ~b_mask) | (wdata & b_mask);
        end
    end

    assign summ = ext_variant && (|((c_q | d_q) & E_W1C_EXT));

    always_comb begin
        case (dec.tgt)
            TG_A:    rd_word = (a_q & A_RMASK) | (32'(summ) << A_SUMM_BIT);
            TG_B:    rd_word = (b_q & B_RMASK) | B_FORCE;
            TG_C:    rd_word = c_q & (ext_variant ? E_RMASK_EXT : E_RMASK_BASIC);
            TG_D:    rd_word = d_q & E_RMASK_EXT;
            TG_ROM:  rd_word = rom_q;
            default: rd_word = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            resp    <= RSP_OK;
            rdata   <= '0;
            errconf <= 1'b0;
        end else begin
            ack     <= req;
            resp    <= req ? dec.rsp : RSP_OK;
            rdata   <= (good && !wr) ? rd_word : 32'd0;
            errconf <= bad;
        end
    end

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> ack);

    // R2
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ack);

    // R3
    bad_access_chk: assert property (@(posedge clk) disable iff (rst)
        (req && (!is_long || addr[1:0] != 2'b00)) |=> (ack && resp == 2'd2 && errconf));

    // R3
    bad_access_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (req && (!is_long || addr[1:0] != 2'b00)) |=> ($stable(a_q) && $stable(b_q)));

    // R3
    errconf_only_bad_chk: assert property (@(posedge clk) disable iff (rst)
        errconf |-> (ack && resp == 2'd2));

    // R4
    a_ilv_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (req && wr && is_long && addr == ADDR_W'(0) && !wdata[8]) |=> $stable(a_q[2:0]));

    // R5
    b_start_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (req && wr && is_long && addr == ADDR_W'(4) && !wdata[14]) |=> $stable(b_q[27:15]));

    // R8
    basic_d_absent_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ext_variant && is_long && addr == ADDR_W'(12)) |=> (resp == 2'd1));
endmodule

// File: tb/test_memctl_csr.sv
`timescale 1ns/1ps
module test_memctl_csr;
    localparam int          AW   = 13;
    localparam int          IDX  = 1;
    localparam int          KB   = 1024;
    localparam int          RW   = 16;
    localparam logic [31:0] SEED = 32'hC0DE_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext = 1'b0;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic          lw = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   sc = '0;
    logic [31:0]   sd = '0;
    wire           ack;
    wire  [1:0]    resp;
    wire  [31:0]   rdata;
    wire           errconf;

    always #2 clk = ~clk;

    memctl_csr #(.ADDR_W(AW), .CTRL_IDX(IDX), .SIZE_KB(KB), .ROM_WORDS(RW), .ROM_SEED(SEED)) i_memctl_csr (
        .clk(clk), .rst(rst), .ext_variant(ext), .req(req), .wr(wr), .is_long(lw),
        .addr(addr), .wdata(wdata), .set_c(sc), .set_d(sd),
        .ack(ack), .resp(resp), .rdata(rdata), .errconf(errconf)
    );

    // behavioural reference model state
    logic [31:0] mA, mB, mC, mD, eR, clr, rmc;
    logic [1:0]  eResp;
    logic        eAck = 1'b0, eErr = 1'b0, armed = 1'b0, summ;
    integer      ofs;
    string       tag = "R1";
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 1'b0;

    function automatic logic [31:0] model_reset_a(input logic e);
        int mb;
        mb = KB / 1024;
        if (e) return ((mb - 1) * 512) + ((mb <= 16) ? 32'h68 : 32'h70);
        return ((KB / 64 - 1) * 512) + ((KB <= 1024) ? 32'h08 : 32'h10);
    endfunction

    always @(posedge clk) begin
        armed = 1'b1;
        if (rst) begin
            mA = model_reset_a(ext);
            mB = 32'h3000 | ((IDX * KB) * 512);
            mC = 0; mD = 0;
            eAck = 0; eResp = 0; eR = 0; eErr = 0;
        end else begin
            clr  = ext ? 32'h300C_0380 : 32'h3000_0000;
            rmc  = ext ? 32'h700C_0380 : 32'h7FFF_FFFF;
            summ = ext && (((mC | mD) & 32'h300C_0380) != 0);
            eAck = req; eResp = 0; eR = 0; eErr = 0;
            if (req) begin
                if (!lw || addr[1:0] != 2'b00) begin
                    eResp = 2; eErr = 1;
                end else begin
                    ofs = int'(addr) / 4;
                    if (ofs == 0) begin
                        if (wr) begin
                            mA[8] = wdata[8];
                            if (wdata[8]) mA[2:0] = wdata[2:0];
                        end else begin
                            eR = mA & 32'h7FFF;
                            eR[20] = summ;
                        end
                    end else if (ofs == 1) begin
                        if (wr) begin
                            mB[10:0] = wdata[10:0];
                            mB[14]   = wdata[14];
                            if (wdata[14]) mB[27:15] = wdata[27:15];
                        end else begin
                            eR = mB; eR[13:12] = 2'b11; eR[11] = 1'b0;
                        end
                    end else if (ofs == 2) begin
                        if (wr) begin
                            mC[30] = wdata[30];
                            mC = mC & ~(wdata & clr);
                        end else eR = mC & rmc;
                    end else if (ofs == 3) begin
                        if (!ext) eResp = 1;
                        else if (wr) begin
                            mD[30] = wdata[30];
                            mD = mD & ~(wdata & clr);
                        end else eR = mD & 32'h700C_0380;
                    end else if (ofs >= 1024 && ofs < 1024 + RW && !wr) begin
                        eR = SEED + (ofs - 1024) * 32'h0101_0101;
                    end else begin
                        eResp = 1;
                    end
                end
            end
            mC = mC | (sc & clr);
            if (ext) mD = mD | (sd & clr);
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            compared++;
            if ({ack, resp, rdata, errconf} !== {eAck, eResp, eR, eErr}) begin
                mismatched++;
                $display("FAIL %s: got ack=%0b resp=%0d rdata=%08h errconf=%0b, expected ack=%0b resp=%0d rdata=%08h errconf=%0b",
                         tag, ack, resp, rdata, errconf, eAck, eResp, eR, eErr);
            end
        end
    end

    task automatic acc(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                       input bit l = 1'b1, input logic [31:0] c = 0, input logic [31:0] dd = 0);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; lw = l; sc = c; sd = dd;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; lw = 1'b1; sc = 0; sd = 0;
    endtask

    task automatic pulse(input logic [31:0] c, input logic [31:0] dd);
        @(negedge clk);
        sc = c; sd = dd;
        @(negedge clk);
        sc = 0; sd = 0;
    endtask

    task automatic run_variant(input bit e);
        @(negedge clk);
        rst = 1'b1; ext = e; tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset contents
        acc(0, 13'h0, 0); acc(0, 13'h4, 0); acc(0, 13'h8, 0);
        tag = "R8"; acc(0, 13'hC, 0);
        // R3 refused accesses leave A and B untouched
        tag = "R3";
        acc(1, 13'h0, 32'h0000_01FF, 1'b0);
        acc(1, 13'h6, 32'hFFFF_FFFF);
        acc(0, 13'h9, 0);
        acc(0, 13'h0, 0); acc(0, 13'h4, 0);
        // R4 interleave gated by bit 8
        tag = "R4";
        acc(1, 13'h0, 32'hFFFF_F1FF); acc(0, 13'h0, 0);
        acc(1, 13'h0, 32'h0000_0002); acc(0, 13'h0, 0);
        // R5 start address gated by bit 14, forced read bits
        tag = "R5";
        acc(1, 13'h4, 32'hFFFF_BFFF); acc(0, 13'h4, 0);
        acc(1, 13'h4, 32'h0ABC_C955); acc(0, 13'h4, 0);
        // R6 plain bit and write-one clear
        tag = "R6";
        acc(1, 13'h8, 32'h4000_0000); acc(0, 13'h8, 0);
        pulse(32'hFFFF_FFFF, 0); acc(0, 13'h8, 0);
        acc(1, 13'h8, 32'h3000_0000); acc(0, 13'h8, 0);
        // R7 hardware set beats a clear in the same cycle
        tag = "R7";
        pulse(32'hFFFF_FFFF, 0);
        acc(1, 13'h8, 32'hFFFF_FFFF, 1'b1, 32'h1000_0080, 0);
        acc(0, 13'h8, 0);
        // R11 summary reflects C
        tag = "R11"; acc(0, 13'h0, 0);
        acc(1, 13'h8, 32'hFFFF_FFFF); acc(0, 13'h0, 0);
        // R8 register D
        tag = "R8";
        acc(1, 13'hC, 32'h7FFF_FFFF); acc(0, 13'hC, 0);
        pulse(0, 32'hFFFF_FFFF); acc(0, 13'hC, 0);
        acc(1, 13'hC, 32'h0008_0100, 1'b1, 0, 32'h0000_0100); acc(0, 13'hC, 0);
        tag = "R11"; acc(0, 13'h0, 0);
        // R9 non-existent offsets
        tag = "R9";
        acc(0, 13'h10, 0); acc(1, 13'hFFC, 32'h1234_5678);
        acc(1, 13'h1000, 32'hFFFF_FFFF); acc(0, 13'h1000 + AW'(RW * 4), 0);
        // R10 ROM words
        tag = "R10";
        acc(0, 13'h1000, 0); acc(0, 13'h1014, 0); acc(0, 13'h1000 + AW'((RW - 1) * 4), 0);
        // R2 back-to-back requests and idle cycles
        tag = "R2";
        @(negedge clk); req = 1'b1; wr = 1'b0; addr = 13'h4;
        @(negedge clk); addr = 13'h1004;
        @(negedge clk); wr = 1'b1; addr = 13'h0; wdata = 32'h0000_0105;
        @(negedge clk); req = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        run_variant(1'b0);
        run_variant(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++; mismatched++;
            $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule